// File: doc/BRIEF.md
# Triple-Lockstep Majority Voter with Resynchronization Sequencer

This controller sits outside three processors, each in its own device, that run the same program cycle by cycle in lockstep. Every cycle it takes the three processor output buses and forms a bitwise two-of-three majority. Only that majority goes on to the rest of the system, so a single faulty processor cannot corrupt anything downstream. All error detection happens here, in the controller, and not inside the devices that can be upset.

When exactly one processor's bus differs from the majority, the controller marks that processor as faulty. It then repairs it with a fixed handshake:

1. It requests a configuration reload of that processor's device.
2. It waits for the device to report that the reload is done.
3. It requests a state reload from the healthy pair.
4. When the state reload completes, it clears the fault.

Throughout the repair the other two processors keep running and drive the output, so the system sees no outage. Only one repair runs at a time. A disagreement the controller cannot correct sets a sticky flag.

Top module: `tmr_resync_ctrl`

## Requirements
- R1: While no repair is in progress, each bit of `voted` is the majority of that bit across the three processor buses. The output is combinational in the current inputs.
- R2: While no repair is in progress, suppose exactly one processor bus differs from the majority in at least one bit. Then after the next rising clock edge `fault` is one-hot at that processor (bit i = processor i) and `reconfig_req` carries the same one-hot value.
- R3: While no repair is in progress, suppose two or more processor buses differ from the majority. Then after the next edge `uncorrectable` is 1, and no fault is started.
- R4: During a repair, the bus of the processor under repair has no effect: it does not change `voted`, `fault` or `uncorrectable`. `voted` equals the bus of the lower-numbered healthy processor.
- R5: During a repair, if the two healthy buses differ, `uncorrectable` is 1 after the next edge.
- R6: `reconfig_req` holds until the edge at which the matching `cfg_done` bit is 1, and from then on `reload_req` carries the same one-hot value. `cfg_done` bits for other processors have no effect.
- R7: `reload_req` holds until the edge at which the matching `reload_done` bit is 1, and from then on `fault` and `reload_req` are zero. `reload_done` bits for other processors have no effect.
- R8: After reset `fault`, `reconfig_req`, `reload_req` and `uncorrectable` are all zero.
- R9: Once set, `uncorrectable` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_bus | input | 3×W | Output buses of processors 0..2 (index = processor) |
| voted | output | W | Voted bus forwarded to the system |
| fault | output | 3 | One-hot flag of the processor under repair |
| reconfig_req | output | 3 | Device configuration reload request, per processor |
| cfg_done | input | 3 | Configuration reload finished, per processor |
| reload_req | output | 3 | State reload request, per processor |
| reload_done | input | 3 | State reload finished, per processor |
| uncorrectable | output | 1 | Sticky flag for a disagreement that cannot be corrected |

## Verification
The bench sweeps every combination of three 4-bit buses against an arithmetic bit count, which catches a voter that uses AND or OR in place of majority. For each processor in turn it then drives every value onto the processor under repair, to catch a design that keeps voting it or re-flags it. It also pulses the done inputs of the wrong processors, which a controller that ignores the victim index would wrongly accept. Finally it forces split disagreements, both while running and while repairing, and then restores agreement, so that a flag that fails to rise or fails to stick is reported.

// File: rtl/tmr_resync_ctrl.sv
module tmr_resync_ctrl #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0][W-1:0]   proc_bus,
  output logic [W-1:0]        voted,
  output logic [2:0]          fault,
  output logic [2:0]          reconfig_req,
  input  logic [2:0]          cfg_done,
  output logic [2:0]          reload_req,
  input  logic [2:0]          reload_done,
  output logic                uncorrectable
);

  typedef enum logic [1:0] {S_RUN, S_CFG, S_LOAD} st_t;

  st_t        st;
  logic [1:0] vic;
  logic       unc_q;
  logic [W-1:0] maj;
  logic [2:0] diff;
  logic [1:0] lo, hi;
  logic       pair_mis;
  logic [2:0] vic_oh;

  assign maj = (proc_bus[0] & proc_bus[1]) | (proc_bus[0] & proc_bus[2]) |
               (proc_bus[1] & proc_bus[2]);

  for (genvar i = 0; i < 3; i++) begin : g_diff
    assign diff[i] = |(proc_bus[i] ^ maj);
  end

  assign lo       = (vic == 2'd0) ? 2'd1 : 2'd0;
  assign hi       = (vic == 2'd2) ? 2'd1 : 2'd2;
  assign pair_mis = proc_bus[lo] != proc_bus[hi];
  assign vic_oh   = 3'b001 << vic;

  assign voted         = (st == S_RUN) ? maj : proc_bus[lo];
  assign fault         = (st != S_RUN)  ? vic_oh : 3'b000;
  assign reconfig_req  = (st == S_CFG)  ? vic_oh : 3'b000;
  assign reload_req    = (st == S_LOAD) ? vic_oh : 3'b000;
  assign uncorrectable = unc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_RUN;
      vic   <= 2'd0;
      unc_q <= 1'b0;
    end else begin
      unique case (st)
        S_RUN: begin
          if ($countones(diff) == 1) begin
            st  <= S_CFG;
            vic <= diff[2] ? 2'd2 : (diff[1] ? 2'd1 : 2'd0);
          end else if ($countones(diff) > 1) begin
            unc_q <= 1'b1;
          end
        end
        S_CFG: begin
          if (cfg_done[vic]) st <= S_LOAD;
          if (pair_mis) unc_q <= 1'b1;
        end
        S_LOAD: begin
          if (reload_done[vic]) st <= S_RUN;
          if (pair_mis) unc_q <= 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  a_r2_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault));

  a_r2_flag_minority: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == 3'b000 && $countones(diff) == 1) |=> (fault == $past(diff)));

  a_r4_pair_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != 3'b000) |-> ((!fault[0] && voted == proc_bus[0]) ||
                           (!fault[1] && voted == proc_bus[1])));

  a_r6_cfg_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    (|(reconfig_req & cfg_done)) |=> (reload_req == $past(reconfig_req)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|(reload_req & reload_done)) |=> (fault == 3'b000 && reload_req == 3'b000));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uncorrectable) |-> uncorrectable);

endmodule

// File: tb/sim_tmr_resync_ctrl.sv
module sim_tmr_resync_ctrl;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][W-1:0] proc_bus = '0;
  logic [W-1:0] voted;
  logic [2:0] fault, reconfig_req, reload_req;
  logic [2:0] cfg_done = 3'b0, reload_done = 3'b0;
  logic uncorrectable;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  tmr_resync_ctrl #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_bus(proc_bus), .voted(voted),
    .fault(fault), .reconfig_req(reconfig_req), .cfg_done(cfg_done),
    .reload_req(reload_req), .reload_done(reload_done),
    .uncorrectable(uncorrectable));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    proc_bus[0] = a; proc_bus[1] = b; proc_bus[2] = c;
  endtask

  task automatic do_reset();
    rst_n = 0; put(0, 0, 0); cfg_done = 0; reload_done = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  function automatic logic [W-1:0] majv(input int a, input int b, input int c);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      int s;
      s = ((a >> k) & 1) + ((b >> k) & 1) + ((c >> k) & 1);
      r[k] = (s >= 2);
    end
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R8 fault", {29'b0, fault}, 0);
    chk("R8 reconfig_req", {29'b0, reconfig_req}, 0);
    chk("R8 reload_req", {29'b0, reload_req}, 0);
    chk("R8 uncorrectable", {31'b0, uncorrectable}, 0);

    // R1 exhaustive vote sweep while held in the idle state
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          put(a[W-1:0], b[W-1:0], c[W-1:0]);
          #1;
          chk("R1 vote", {28'b0, voted}, {28'b0, majv(a, b, c)});
        end

    for (int v = 0; v < 3; v++) begin
      logic [2:0] oh;
      oh = 3'b001 << v;
      do_reset();
      put(5, 5, 5); proc_bus[v] = 4'hA;
      #1;
      chk("R1 masked minority", {28'b0, voted}, 5);
      tick();
      chk("R2 fault", {29'b0, fault}, {29'b0, oh});
      chk("R2 reconfig_req", {29'b0, reconfig_req}, {29'b0, oh});
      for (int x = 0; x < 16; x++) begin
        proc_bus[v] = x[W-1:0];
        tick();
        chk("R4 voted", {28'b0, voted}, 5);
        chk("R4 fault", {29'b0, fault}, {29'b0, oh});
        chk("R4 uncorrectable", {31'b0, uncorrectable}, 0);
      end
      cfg_done = ~oh;
      tick();
      chk("R6 foreign cfg_done reload", {29'b0, reload_req}, 0);
      chk("R6 foreign cfg_done reconfig", {29'b0, reconfig_req}, {29'b0, oh});
      cfg_done = oh;
      tick();
      cfg_done = 0;
      chk("R6 reload_req", {29'b0, reload_req}, {29'b0, oh});
      chk("R6 reconfig dropped", {29'b0, reconfig_req}, 0);
      reload_done = ~oh;
      tick();
      chk("R7 foreign reload_done", {29'b0, fault}, {29'b0, oh});
      reload_done = oh;
      tick();
      reload_done = 0;
      put(5, 5, 5);
      chk("R7 fault cleared", {29'b0, fault}, 0);
      chk("R7 reload_req cleared", {29'b0, reload_req}, 0);
      tick();
      chk("R7 stays idle", {29'b0, fault}, 0);
      chk("R7 no false unc", {31'b0, uncorrectable}, 0);
    end

    // R3 split disagreement while running, then R9 stickiness
    do_reset();
    put(0, 1, 2);
    tick();
    chk("R3 uncorrectable", {31'b0, uncorrectable}, 1);
    chk("R3 no fault", {29'b0, fault}, 0);
    put(7, 7, 7);
    tick(); tick();
    chk("R9 sticky", {31'b0, uncorrectable}, 1);

    // R5 healthy pair disagreement during repair
    do_reset();
    put(9, 6, 6);
    tick();
    chk("R5 setup fault", {29'b0, fault}, 1);
    put(9, 3, 4);
    #1;
    chk("R4 lower healthy drives", {28'b0, voted}, 3);
    tick();
    chk("R5 uncorrectable", {31'b0, uncorrectable}, 1);
    put(6, 6, 6);
    tick();
    chk("R9 sticky in repair", {31'b0, uncorrectable}, 1);
    do_reset();
    tick();
    chk("R8 reset clears unc", {31'b0, uncorrectable}, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end
endmodule